// File: doc/BRIEF.md
# Maskable Latched Interrupt Controller

This block gathers up to 32 interrupt request lines beside a processor core. Each line has a pending bit that latches a request and a matching enable bit. The core sees a single request output. That output is high whenever some line is both pending and enabled. There is no priority logic and no vector output. Software reads the pending register and services the lines it finds, normally starting from the lowest set bit.

Two registers are reached through a small register port. One select bit chooses the enable register (0) or the pending register (1). A write strobe with 32-bit data updates the chosen register. Read data is registered: it appears in the cycle after the select is presented.

A build-time parameter sets the acknowledge polarity:
- In one-clears mode, a 1 written to a pending bit clears it.
- In zero-clears mode, a 0 clears it, so software writes back the value it read with only the target bit cleared.

A per-line parameter chooses, for each line, either rising-edge capture or level capture. Level-captured requests are also sticky and must be acknowledged.

Top module: `irq_latch_ctrl`

## Requirements
- R1: After reset the enable register, the pending register, the read data and `core_irq` are all 0.
- R2: A write with `reg_sel`=0 loads `reg_wdata` into the enable register. Bit n enables line n. A later read with `reg_sel`=0 returns the value written.
- R3: A line marked for edge capture (its bit in `EDGE_LINES` is 1) sets its pending bit on the clock edge where the input is 1 and was 0 one cycle before. The bit stays set until it is acknowledged. An input held high does not set the bit again after an acknowledge.
- R4: A line marked for level capture sets its pending bit on every clock edge where the input is 1. The bit stays set after the input falls, until it is acknowledged.
- R5: With `CLEAR_ON_ONE`=1, a write with `reg_sel`=1 clears every pending bit whose `reg_wdata` bit is 1. Pending bits whose data bit is 0 keep their value.
- R6: With `CLEAR_ON_ONE`=0, a write with `reg_sel`=1 clears every pending bit whose `reg_wdata` bit is 0. Pending bits whose data bit is 1 keep their value.
- R7: If a line's capture condition (R3 or R4) and an acknowledge of that line fall on the same edge, the bit stays pending.
- R8: `core_irq` is 1 in the same cycle that any bit is set in both the pending and the enable registers, and 0 otherwise (default `IRQ_FLOP`=0).
- R9: `reg_rdata` in the cycle after an edge equals the register chosen by `reg_sel` at that edge, as it stood before that edge's update. Pending bit n is at data bit n.
- R10: A write to the pending register never sets a pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | LINES | Request lines, one per bit |
| reg_sel | input | 1 | 0 selects enable register, 1 selects pending register |
| reg_we | input | 1 | Write strobe for the selected register |
| reg_wdata | input | LINES | Write data |
| reg_rdata | output | LINES | Registered read data |
| core_irq | output | 1 | Request to the core |

## Verification
The assertions take the request lines and the register port to be synchronous to `clk`, with defined values from the first edge after reset is released. The embedded properties compare pending bits with the previous cycle's inputs, so they rely on this. The bench therefore changes every input only on the falling clock edge and keeps all inputs at known values throughout reset. The bench also keeps `reg_sel` at the pending register whenever it is idle. This lets the per-cycle comparison observe the pending state through the read port in every cycle.

// File: rtl/irq_latch_ctrl.sv
module irq_latch_ctrl #(
  parameter int               LINES        = 32,
  parameter bit               CLEAR_ON_ONE = 1'b1,
  parameter logic [LINES-1:0] EDGE_LINES   = LINES'(32'h0000_FFFF),
  parameter bit               IRQ_FLOP     = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] irq_in,
  input  logic             reg_sel,
  input  logic             reg_we,
  input  logic [LINES-1:0] reg_wdata,
  output logic [LINES-1:0] reg_rdata,
  output logic             core_irq
);

  logic [LINES-1:0] en_q, pend_q, in_d, hit, wipe;
  logic             pend_wr;

  assign pend_wr = reg_we & reg_sel;
  assign hit     = (irq_in & ~in_d & EDGE_LINES) | (irq_in & ~EDGE_LINES);
  assign wipe    = pend_wr ? (CLEAR_ON_ONE ? reg_wdata : ~reg_wdata) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q      <= '0;
      pend_q    <= '0;
      in_d      <= '0;
      reg_rdata <= '0;
    end else begin
      in_d      <= irq_in;
      pend_q    <= (pend_q & ~wipe) | hit;
      reg_rdata <= reg_sel ? pend_q : en_q;
      if (reg_we && !reg_sel) en_q <= reg_wdata;
    end
  end

  generate
    if (IRQ_FLOP) begin : g_irq_reg
      always_ff @(posedge clk) begin
        if (!rst_n) core_irq <= 1'b0;
        else        core_irq <= |(pend_q & en_q);
      end
    end else begin : g_irq_comb
      assign core_irq = |(pend_q & en_q);
      AST_IRQ_DROP_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $fell(core_irq) |-> $past(reg_we)); // R8
    end
  endgenerate

  AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> pend_q == '0 && en_q == '0); // R1

  AST_ENABLE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we && !reg_sel |=> en_q == $past(reg_wdata)); // R2

  AST_STICKY_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (($past(pend_q) & ~$past(wipe)) & ~pend_q) == '0); // R3

  AST_LEVEL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ($past(irq_in) & ~EDGE_LINES & ~pend_q) == '0); // R7

  AST_NO_SOFT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((pend_q & ~$past(pend_q)) & ~$past(irq_in)) == '0); // R10

endmodule

// File: tb/sim_irq_latch_ctrl.sv
module sim_irq_latch_ctrl;
  localparam int N = 32;
  localparam logic [N-1:0] EDGES = 32'h0000_FFFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] irq_in = '0;
  logic reg_sel = 1'b1;
  logic reg_we = 1'b0;
  logic [N-1:0] reg_wdata = '0;
  logic [N-1:0] rd0, rd1;
  logic irq0, irq1;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  string tag = "R1";

  always #4 clk = ~clk;

  irq_latch_ctrl #(.LINES(N), .CLEAR_ON_ONE(1'b1), .EDGE_LINES(EDGES)) u0 (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_sel(reg_sel), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(rd0), .core_irq(irq0));

  irq_latch_ctrl #(.LINES(N), .CLEAR_ON_ONE(1'b0), .EDGE_LINES(EDGES)) u1 (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_sel(reg_sel), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(rd1), .core_irq(irq1));

  // behavioural reference, index 0 = one-clears, 1 = zero-clears
  bit m_en [2][N];
  bit m_pend [2][N];
  bit m_rd [2][N];
  bit m_prev [N];

  always @(posedge clk) begin
    for (int k = 0; k < 2; k++) begin
      for (int b = 0; b < N; b++) begin
        bit req, ack;
        if (!rst_n) begin
          m_en[k][b] = 0; m_pend[k][b] = 0; m_rd[k][b] = 0;
        end else begin
          m_rd[k][b] = reg_sel ? m_pend[k][b] : m_en[k][b];
          req = EDGES[b] ? (irq_in[b] && !m_prev[b]) : irq_in[b];
          ack = reg_we && reg_sel && (k == 0 ? reg_wdata[b] : !reg_wdata[b]);
          if (req) m_pend[k][b] = 1;
          else if (ack) m_pend[k][b] = 0;
          if (reg_we && !reg_sel) m_en[k][b] = reg_wdata[b];
        end
      end
    end
    for (int b = 0; b < N; b++) m_prev[b] = rst_n ? irq_in[b] : 1'b0;
  end

  function automatic logic [N-1:0] pack(input int k, input bit which);
    logic [N-1:0] v;
    for (int b = 0; b < N; b++) v[b] = which ? m_rd[k][b] : m_pend[k][b];
    return v;
  endfunction

  function automatic bit want_irq(input int k);
    bit any = 0;
    for (int b = 0; b < N; b++) if (m_pend[k][b] && m_en[k][b]) any = 1;
    return any;
  endfunction

  task automatic check(input string req, input string what, input logic [N-1:0] got, input logic [N-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, got, exp);
    end
  endtask

  // per-cycle comparison against the reference
  always @(posedge clk) begin
    #2;
    if (!done) begin
      check(tag, "u0 rdata", rd0, pack(0, 1));
      check(tag, "u1 rdata", rd1, pack(1, 1));
      check((tag == "R8") ? "R8" : tag, "u0 core_irq", {31'b0, irq0}, {31'b0, want_irq(0)});
      check((tag == "R8") ? "R8" : tag, "u1 core_irq", {31'b0, irq1}, {31'b0, want_irq(1)});
    end
  end

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input bit sel, input logic [N-1:0] d);
    reg_sel = sel; reg_we = 1'b1; reg_wdata = d;
    tick();
    reg_we = 1'b0; reg_sel = 1'b1; reg_wdata = '0;
  endtask

  task automatic report;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      report();
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(2);
    tag = "R1";
    check("R1", "u0 pending after reset", rd0, '0);
    check("R1", "u0 core_irq after reset", {31'b0, irq0}, '0);

    tag = "R2";
    wr(1'b0, 32'h0000_00F3);
    reg_sel = 1'b0; tick(2);
    check("R2", "u0 enable readback", rd0, 32'h0000_00F3);
    check("R2", "u1 enable readback", rd1, 32'h0000_00F3);
    reg_sel = 1'b1;
    wr(1'b0, 32'hFFFF_FFFF);

    tag = "R3";
    irq_in[2] = 1'b1; tick(); irq_in[2] = 1'b0; tick(2);
    check("R3", "edge pulse latched", rd0 & 32'h4, 32'h4);
    irq_in[5] = 1'b1; tick(2);
    wr(1'b1, 32'h0000_0020);
    tick(3);
    check("R3", "held edge line not re-set", rd0 & 32'h20, '0);
    irq_in[5] = 1'b0; tick();

    tag = "R4";
    irq_in[20] = 1'b1; tick(2); irq_in[20] = 1'b0; tick(3);
    check("R4", "level bit sticky after drop", rd0 & 32'h0010_0000, 32'h0010_0000);
    irq_in[21] = 1'b1; tick();
    wr(1'b1, 32'h0020_0000);
    tick(2);
    check("R4", "level bit while high survives ack", rd0 & 32'h0020_0000, 32'h0020_0000);
    irq_in[21] = 1'b0; tick();

    tag = "R5";
    wr(1'b1, 32'h0010_0004);
    tick(2);
    check("R5", "u0 ones cleared only", rd0, 32'h0020_0000);

    tag = "R6";
    wr(1'b1, ~32'h0020_0000);
    tick(2);
    check("R6", "u1 only zero bit cleared", rd1 & 32'h0020_0000, '0);

    tag = "R7";
    wr(1'b1, 32'hFFFF_FFFF);
    wr(1'b1, 32'h0000_0000);
    tick();
    irq_in[3] = 1'b1; reg_sel = 1'b1; reg_we = 1'b1; reg_wdata = 32'h0000_0008;
    tick();
    reg_we = 1'b0; reg_wdata = '0; irq_in[3] = 1'b0;
    tick(2);
    check("R7", "set beats clear", rd0 & 32'h8, 32'h8);

    tag = "R8";
    wr(1'b0, 32'h0000_0000);
    tick();
    check("R8", "masked pending gives no irq", {31'b0, irq0}, '0);
    reg_sel = 1'b0; reg_we = 1'b1; reg_wdata = 32'h0000_0008;
    @(posedge clk); #1;
    check("R8", "irq same cycle as enable", {31'b0, irq0}, 32'h1);
    @(negedge clk);
    reg_we = 1'b0; reg_sel = 1'b1; reg_wdata = '0;
    wr(1'b1, 32'h0000_0008);
    tick();
    check("R8", "irq drops after ack", {31'b0, irq0}, '0);

    tag = "R9";
    irq_in[30] = 1'b1; irq_in[9] = 1'b1; tick(); irq_in = '0;
    tick();
    check("R9", "status bit positions", rd0 & 32'h4000_0200, 32'h4000_0200);
    wr(1'b1, 32'h4000_0200);
    tick(2);

    tag = "R10";
    wr(1'b1, 32'h0000_0000);
    wr(1'b1, 32'hFFFF_FFFF);
    tick(2);
    check("R10", "u0 write never sets", rd0, '0);
    check("R10", "u1 write never sets", rd1, pack(1, 0));

    done = 1'b1;
    tick();
    report();
  end
endmodule